// File: doc/BRIEF.md
# Bridge Error Status Register with Bus-Busy Watchdog

This block holds four sticky error flags for a bus bridge inside one 32-bit status word. Three flags capture single-cycle events: a split-completion message reporting a target abort, a split-completion message reporting a byte count out of range, and a non-posted request that arrives while the device terminates the host chain. The fourth flag comes from a watchdog. It counts bus clocks for as long as the bus stays non-idle, meaning either the frame or the initiator-ready line is driven low, and it sets the flag once the bus has been busy for 49152 clocks in a row.

Software reads the whole word through `rd_data` and clears individual flags by writing ones. Only the power-good input clears the flags as a group. The bridge reset input leaves them untouched. The watchdog flag can be cleared only after a bridge reset, so software first has to recover the stuck bus. A parameter selects whether this instance implements the end-of-chain flag or treats that bit as reserved.

Top module: `bridge_err_status`

## Requirements
- R1: Bits 31:20 and 15:0 of `rd_data` always read zero. Bit 19 also reads zero when the parameter `EOC_IMPL` is 0.
- R2: While `pwrgood_n` is low, `rd_data` is zero, with no clock edge required. After release, all flags stay zero until an event sets them.
- R3: Bit 19 (end-of-chain request) sets one edge after a cycle in which `np_req` and `eoc_mode` are both high. `np_req` with `eoc_mode` low has no effect.
- R4: Bit 18 (busy timeout) sets at the clock edge on which `frame_n` or `irdy_n` has been sampled low on 49152 consecutive edges (`TIMEOUT_CLKS`), and not earlier.
- R5: The busy count restarts on any edge where `frame_n` and `irdy_n` are both high. Once it reaches the limit it saturates, so a bus that stays busy does not set bit 18 again.
- R6: Bit 17 sets one edge after `scm_valid` is high with class 1 and index 01h. Bit 16 sets one edge after `scm_valid` is high with class 2 and index 00h. Any other class/index pair, or `scm_valid` low, has no effect.
- R7: When `wr_en` is high, a one in bit 19, 17 or 16 of `wr_data` clears that flag at the next edge. Zeros and reserved bits have no effect.
- R8: A write of one to bit 18 clears the timeout flag only if `bridge_rst` has been high on at least one edge since the timeout last set. Otherwise the write has no effect.
- R9: When a set event and a write-one clear for the same flag arrive in the same cycle, the flag is set after the edge.
- R10: `bridge_rst` does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwrgood_n | input | 1 | Power-good, active low asynchronous reset of all state |
| bridge_rst | input | 1 | Bridge reset indication, arms clearing of the timeout flag |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| scm_valid | input | 1 | Strobe for a decoded split-completion message |
| scm_class | input | 4 | Message class |
| scm_index | input | 8 | Message index |
| eoc_mode | input | 1 | Device is the end of the host chain |
| np_req | input | 1 | Strobe for a non-posted request routed to the chain end |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones clear flags |
| rd_data | output | 32 | Status word |

## Verification
Event flags and write clears take effect on the first rising edge after the cycle that carries the stimulus. The bench drives each stimulus at a falling edge and compares `rd_data` at the next falling edge. The timeout flag becomes visible after the edge that samples the 49152nd consecutive busy cycle. The bench therefore checks at 49151 busy edges that the flag is still clear, and again one edge later that it has set. A power-good drop is checked a few nanoseconds into the low phase, between clock edges, to confirm the asynchronous reset path.

// File: rtl/bridge_err_pkg.sv
package bridge_err_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FLAG_LSB  = 16;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned CLASS_W   = 4;
  localparam int unsigned INDEX_W   = 8;

  localparam int unsigned IDX_BCOR   = 0;
  localparam int unsigned IDX_TABORT = 1;
  localparam int unsigned IDX_TO     = 2;
  localparam int unsigned IDX_EOC    = 3;

  localparam logic [CLASS_W-1:0] SCM_TABORT_CLASS = 4'd1;
  localparam logic [INDEX_W-1:0] SCM_TABORT_INDEX = 8'h01;
  localparam logic [CLASS_W-1:0] SCM_BCOR_CLASS   = 4'd2;
  localparam logic [INDEX_W-1:0] SCM_BCOR_INDEX   = 8'h00;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/sticky_w1c.sv
module sticky_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_q;

  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/scm_decode.sv
module scm_decode
  import bridge_err_pkg::*;
(
  input  logic               valid_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [INDEX_W-1:0] index_i,
  output logic               tabort_o,
  output logic               bcor_o
);
  always_comb begin
    tabort_o = valid_i && (class_i == SCM_TABORT_CLASS) && (index_i == SCM_TABORT_INDEX);
    bcor_o   = valid_i && (class_i == SCM_BCOR_CLASS)   && (index_i == SCM_BCOR_INDEX);
  end
endmodule

// File: rtl/busy_watchdog.sv
module busy_watchdog #(
  parameter int unsigned LIMIT = 49152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic bridge_rst,
  output logic hit_o,
  output logic clr_ok_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             armed_d, armed_q;
  logic             cnt_en;

  assign busy   = !frame_n || !irdy_n;
  assign cnt_en = busy && (cnt_q != CNT_MAX);
  assign hit_o  = busy && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!busy)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    armed_d = armed_q;
    if (hit_o)      armed_d = 1'b0;
    if (bridge_rst) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign clr_ok_o = armed_q;
endmodule

// File: rtl/bridge_err_status.sv
module bridge_err_status
  import bridge_err_pkg::*;
#(
  parameter bit          EOC_IMPL     = 1'b1,
  parameter int unsigned TIMEOUT_CLKS = 49152
) (
  input  logic               clk,
  input  logic               pwrgood_n,
  input  logic               bridge_rst,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic               scm_valid,
  input  logic [CLASS_W-1:0] scm_class,
  input  logic [INDEX_W-1:0] scm_index,
  input  logic               eoc_mode,
  input  logic               np_req,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       to_hit, to_clr_ok, tabort_ev, bcor_ev;
  flag_vec_t  flag_set, flag_clr, flag_q;
  logic       unused_bits;

  always_ff @(posedge clk or negedge pwrgood_n) begin
    if (!pwrgood_n) rst_sync_q <= 2'b00;
    else            rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  busy_watchdog #(.LIMIT(TIMEOUT_CLKS)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .bridge_rst (bridge_rst),
    .hit_o      (to_hit),
    .clr_ok_o   (to_clr_ok)
  );

  scm_decode u_scm (
    .valid_i  (scm_valid),
    .class_i  (scm_class),
    .index_i  (scm_index),
    .tabort_o (tabort_ev),
    .bcor_o   (bcor_ev)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[IDX_BCOR]   = bcor_ev;
    flag_set[IDX_TABORT] = tabort_ev;
    flag_set[IDX_TO]     = to_hit;
    flag_set[IDX_EOC]    = eoc_mode && np_req;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      flag_clr[i] = wr_en && wr_data[FLAG_LSB + i];
    end
    flag_clr[IDX_TO] = flag_clr[IDX_TO] && to_clr_ok;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    if (g == IDX_EOC && !EOC_IMPL) begin : g_rsvd
      assign flag_q[g] = 1'b0;
    end else begin : g_impl
      sticky_w1c u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set[g]),
        .clr_i (flag_clr[g]),
        .q_o   (flag_q[g])
      );
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[FLAG_LSB +: NUM_FLAGS] = flag_q;
  end

  assign unused_bits = ^{wr_data[REG_W-1:FLAG_LSB+NUM_FLAGS], wr_data[FLAG_LSB-1:0],
                         flag_set, flag_clr};
endmodule

// File: rtl/bridge_err_status_chk.sv
module bridge_err_status_chk #(
  parameter bit          EOC_IMPL     = 1'b1,
  parameter int unsigned TIMEOUT_CLKS = 49152
) (
  input logic        clk,
  input logic        pwrgood_n,
  input logic        bridge_rst,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        scm_valid,
  input logic [3:0]  scm_class,
  input logic [7:0]  scm_index,
  input logic        eoc_mode,
  input logic        np_req,
  input logic        wr_en,
  input logic [3:0]  wr_clr,
  input logic [31:0] rd_data
);
  localparam int unsigned SW = $clog2(TIMEOUT_CLKS + 1);
  logic [SW-1:0] streak_q;

  always_ff @(posedge clk or negedge pwrgood_n) begin
    if (!pwrgood_n)                 streak_q <= '0;
    else if (frame_n && irdy_n)     streak_q <= '0;
    else if (streak_q != SW'(TIMEOUT_CLKS)) streak_q <= streak_q + 1'b1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!pwrgood_n)
    (rd_data[31:20] == 12'h000) && (rd_data[15:0] == 16'h0000)); // R1

  AST_TABORT_SET: assert property (@(posedge clk) disable iff (!pwrgood_n)
    (scm_valid && scm_class == 4'd1 && scm_index == 8'h01) |=> rd_data[17]); // R6

  AST_BCOR_SET: assert property (@(posedge clk) disable iff (!pwrgood_n)
    (scm_valid && scm_class == 4'd2 && scm_index == 8'h00) |=> rd_data[16]); // R6

  AST_TABORT_STICKY: assert property (@(posedge clk) disable iff (!pwrgood_n)
    $fell(rd_data[17]) |-> $past(wr_en && wr_clr[1])); // R7

  AST_BCOR_STICKY: assert property (@(posedge clk) disable iff (!pwrgood_n)
    $fell(rd_data[16]) |-> $past(wr_en && wr_clr[0])); // R7

  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!pwrgood_n)
    $fell(rd_data[18]) |-> $past(wr_en && wr_clr[2])); // R8

  AST_TO_WINDOW: assert property (@(posedge clk) disable iff (!pwrgood_n)
    $rose(rd_data[18]) |-> (streak_q == SW'(TIMEOUT_CLKS))); // R4

  AST_BRST_KEEPS: assert property (@(posedge clk) disable iff (!pwrgood_n)
    (bridge_rst && !wr_en) |=> ((rd_data[19:16] & $past(rd_data[19:16])) == $past(rd_data[19:16]))); // R10

  if (EOC_IMPL) begin : g_eoc
    AST_EOC_SET: assert property (@(posedge clk) disable iff (!pwrgood_n)
      (eoc_mode && np_req) |=> rd_data[19]); // R3
  end else begin : g_noeoc
    AST_EOC_RSVD: assert property (@(posedge clk) disable iff (!pwrgood_n)
      !rd_data[19]); // R1
  end
endmodule

bind bridge_err_status bridge_err_status_chk #(
  .EOC_IMPL     (EOC_IMPL),
  .TIMEOUT_CLKS (TIMEOUT_CLKS)
) u_chk (
  .clk        (clk),
  .pwrgood_n  (pwrgood_n),
  .bridge_rst (bridge_rst),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .scm_valid  (scm_valid),
  .scm_class  (scm_class),
  .scm_index  (scm_index),
  .eoc_mode   (eoc_mode),
  .np_req     (np_req),
  .wr_en      (wr_en),
  .wr_clr     (wr_data[19:16]),
  .rd_data    (rd_data)
);

// File: tb/test_bridge_err_status.sv
module test_bridge_err_status;
  localparam int unsigned TO = 49152;

  logic        clk = 1'b0;
  logic        pwrgood_n, bridge_rst, frame_n, irdy_n;
  logic        scm_valid, eoc_mode, np_req, wr_en;
  logic [3:0]  scm_class;
  logic [7:0]  scm_index;
  logic [31:0] wr_data, rd_data, rd_data2;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  bridge_err_status i_bridge_err_status (
    .clk(clk), .pwrgood_n(pwrgood_n), .bridge_rst(bridge_rst), .frame_n(frame_n),
    .irdy_n(irdy_n), .scm_valid(scm_valid), .scm_class(scm_class), .scm_index(scm_index),
    .eoc_mode(eoc_mode), .np_req(np_req), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  bridge_err_status #(.EOC_IMPL(1'b0)) i_bridge_err_status_noeoc (
    .clk(clk), .pwrgood_n(pwrgood_n), .bridge_rst(bridge_rst), .frame_n(frame_n),
    .irdy_n(irdy_n), .scm_valid(scm_valid), .scm_class(scm_class), .scm_index(scm_index),
    .eoc_mode(eoc_mode), .np_req(np_req), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data2)
  );

  function automatic logic [31:0] pack_exp(logic e19, logic e18, logic e17, logic e16);
    return {12'h000, e19, e18, e17, e16, 16'h0000};
  endfunction

  function automatic logic [1:0] scm_hit(logic v, logic [3:0] c, logic [7:0] i);
    return {v && c == 4'd1 && i == 8'h01, v && c == 4'd2 && i == 8'h00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    bridge_rst = 0; frame_n = 1; irdy_n = 1; scm_valid = 0; scm_class = 0;
    scm_index = 0; eoc_mode = 0; np_req = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic wr1(logic [31:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
  endtask

  task automatic scm(logic [3:0] c, logic [7:0] i);
    scm_valid = 1; scm_class = c; scm_index = i; cyc(); scm_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic e19, e18, e17, e16, armed;
    void'($urandom(32'd20250611));
    quiet();
    pwrgood_n = 0;
    repeat (2) @(negedge clk);
    chk("R2 reset", rd_data, 32'h0);
    pwrgood_n = 1;
    repeat (4) cyc();
    chk("R2 after release", rd_data, 32'h0);

    // R3 end-of-chain request
    np_req = 1; eoc_mode = 0; cyc(); np_req = 0;
    chk("R3 np_req without eoc", rd_data, 32'h0);
    np_req = 1; eoc_mode = 1; cyc(); np_req = 0; eoc_mode = 0;
    chk("R3 eoc set", rd_data, pack_exp(1, 0, 0, 0));
    chk("R1 bit19 reserved variant", rd_data2, 32'h0);

    // R7 write-one-to-clear
    wr1(32'hFFF0_FFFF);
    chk("R7 zeros and reserved writes", rd_data, pack_exp(1, 0, 0, 0));
    wr1(32'h0008_0000);
    chk("R7 clear bit19", rd_data, 32'h0);

    // R6 split completion decode
    scm_valid = 0; scm_class = 1; scm_index = 1; cyc();
    chk("R6 valid low", rd_data, 32'h0);
    scm(4'd1, 8'h02);
    chk("R6 class1 other index", rd_data, 32'h0);
    scm(4'd2, 8'h01);
    chk("R6 class2 other index", rd_data, 32'h0);
    scm(4'd1, 8'h01);
    chk("R6 target abort", rd_data, pack_exp(0, 0, 1, 0));
    scm(4'd2, 8'h00);
    chk("R6 byte count", rd_data, pack_exp(0, 0, 1, 1));

    // R9 set beats clear
    scm_valid = 1; scm_class = 1; scm_index = 1;
    wr1(32'h0003_0000); scm_valid = 0;
    chk("R9 set wins", rd_data, pack_exp(0, 0, 1, 0));
    wr1(32'h000F_0000);
    chk("R7 clear all", rd_data, 32'h0);

    // R4/R5 watchdog
    frame_n = 0;
    repeat (TO - 1) cyc();
    chk("R4 one short", rd_data, 32'h0);
    frame_n = 1; cyc();
    chk("R5 idle restart", rd_data, 32'h0);
    frame_n = 0;
    repeat (20000) cyc();
    frame_n = 1; irdy_n = 0;
    repeat (TO - 1 - 20000) cyc();
    chk("R5 restarted count one short", rd_data, 32'h0);
    cyc();
    chk("R4 timeout set", rd_data, pack_exp(0, 1, 0, 0));
    chk("R4 timeout set variant", rd_data2, pack_exp(0, 1, 0, 0));

    // R8 gated clear, R10 bridge reset keeps flags
    wr1(32'h0004_0000);
    chk("R8 clear without bridge reset", rd_data, pack_exp(0, 1, 0, 0));
    scm(4'd1, 8'h01);
    bridge_rst = 1; cyc(); bridge_rst = 0;
    chk("R10 bridge reset keeps flags", rd_data, pack_exp(0, 1, 1, 0));
    wr1(32'h0004_0000);
    chk("R8 clear after bridge reset", rd_data, pack_exp(0, 0, 1, 0));
    repeat (100) cyc();
    chk("R5 saturated no re-set", rd_data, pack_exp(0, 0, 1, 0));
    irdy_n = 1;
    wr1(32'h0002_0000);
    chk("R7 clear bit17", rd_data, 32'h0);

    // random phase, bus idle
    e19 = 0; e18 = 0; e17 = 0; e16 = 0; armed = 1;
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] h;
      scm_valid  = ($urandom % 3) == 0;
      scm_class  = 4'($urandom % 4);
      scm_index  = 8'($urandom % 3);
      eoc_mode   = $urandom % 2;
      np_req     = ($urandom % 6) == 0;
      wr_en      = ($urandom % 5) == 0;
      wr_data    = $urandom;
      bridge_rst = ($urandom % 16) == 0;
      h   = scm_hit(scm_valid, scm_class, scm_index);
      e19 = (eoc_mode && np_req) || (e19 && !(wr_en && wr_data[19]));
      e18 = e18 && !(wr_en && wr_data[18] && armed);
      e17 = h[1] || (e17 && !(wr_en && wr_data[17]));
      e16 = h[0] || (e16 && !(wr_en && wr_data[16]));
      armed = armed || bridge_rst;
      cyc();
      chk("R3 R6 R7 R9 random", rd_data, pack_exp(e19, e18, e17, e16));
      chk("R1 random variant", rd_data2, pack_exp(0, e18, e17, e16));
    end
    quiet();

    // R2 asynchronous power-good
    scm(4'd1, 8'h01);
    chk("R6 before power drop", rd_data, pack_exp(e19, 0, 1, e16));
    #2 pwrgood_n = 0;
    #1 chk("R2 async clear", rd_data, 32'h0);
    @(negedge clk);
    pwrgood_n = 1;
    repeat (3) cyc();
    chk("R2 stays clear", rd_data, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule